// File: doc/BRIEF.md
# Conversion Result Window Qualifier

This block sits behind an analog-to-digital converter and decides which finished conversions are worth an interrupt. Each time the converter reports a new 10-bit result with a single-cycle done pulse, the block compares the result against two limits that software has programmed. It then records whether the result met the chosen criterion. Software picks the criterion with a mode bit: either the result lies between the limits, or it lies beyond them.

If qualification is off, every finished conversion raises the interrupt request, as long as interrupts are enabled. If qualification is on, only results that meet the criterion raise it. Setting one limit at the end of the code range turns the window into a plain threshold detector. Software can then watch for readings above a level, below a level, inside a band or outside a band without polling the converter. The interrupt request stays asserted until software clears it with a write-one-to-clear strobe.

Configuration is written through plain write-enable ports. One data bus is shared by both limits, and one write carries the mode, qualification and interrupt-enable bits together.

Top module: `adc_window_qual`

## Requirements
- R1: After reset, matchFlag and irqReq are 0. The lower limit is 0, the upper limit is all ones (1023), and outside mode, qualification and interrupt enable are all off.
- R2: In inside mode (cfgOutside=0), a result matches when lower <= result <= upper. Both bounds are inclusive.
- R3: In outside mode (cfgOutside=1), a result matches exactly when it would not match in inside mode.
- R4: When the lower limit is greater than the upper limit, no result matches in inside mode and every result matches in outside mode.
- R5: matchFlag changes only in the cycle after a convDone pulse, where it shows the match of that result. Between pulses it holds its value, even while the limits or the mode are rewritten.
- R6: With interrupts enabled and qualification off, every convDone pulse sets irqReq in the following cycle, whatever the result.
- R7: With interrupts and qualification enabled, a convDone pulse sets irqReq only if its result matches. A non-matching result leaves irqReq unchanged.
- R8: With cfgIrqEn=0, no conversion sets irqReq.
- R9: irqReq is sticky. It stays 1 until an irqClr pulse, and it is 0 in the cycle after a clear that arrives with no setting event.
- R10: When an irqClr pulse arrives in the same cycle as a setting event, irqReq is 1 afterwards.
- R11: A limit or configuration write takes effect for a convDone pulse in the next cycle. With the upper limit at 1023 the window acts as an at-or-above threshold. With the lower limit at 0 it acts as an at-or-below threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| limLoWe | input | 1 | Write strobe for the lower limit |
| limHiWe | input | 1 | Write strobe for the upper limit |
| limData | input | 10 | Limit value written by limLoWe or limHiWe |
| cfgWe | input | 1 | Write strobe for the three configuration bits |
| cfgOutside | input | 1 | Mode: 1 means match outside the window, 0 means inside |
| cfgQualEn | input | 1 | 1 gates the interrupt by the match result |
| cfgIrqEn | input | 1 | 1 enables the interrupt request |
| convDone | input | 1 | One-cycle pulse marking a finished conversion |
| convResult | input | 10 | Conversion result, valid with convDone |
| irqClr | input | 1 | Write-one-to-clear pulse for the interrupt request |
| matchFlag | output | 1 | Match result of the most recent conversion |
| irqReq | output | 1 | Sticky interrupt request |

## Verification
A wrong compare, such as an exclusive bound or a mode that does not invert, shows on matchFlag one cycle after the offending pulse. The bench makes it visible by placing results exactly on and next to each limit. A corrupted limit or mode register stays hidden until the next conversion. It then shows as a wrong matchFlag and, with qualification on, as a missing or spurious irqReq in that same following cycle. A flag that drops without a clear, or survives one, shows up at the next result the scoreboard compares.

// File: rtl/adcwin_pkg.sv
package adcwin_pkg;
  // strobes issued by the control to the datapath, one cycle each
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic loadMode;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/adcwin_datapath.sv
module adcwin_datapath
  import adcwin_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobe_t    strb,
  input  logic [W-1:0] limData,
  input  logic         cfgOutside,
  input  logic [W-1:0] convResult,
  output logic         hit,
  output logic         matchFlag
);
  localparam logic [W-1:0] TOP_CODE = {W{1'b1}};

  logic [W-1:0] limLo, limHi;
  logic         outsideMode;
  logic         matchReg;
  logic         geLo, leHi, inWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limLo       <= '0;
      limHi       <= TOP_CODE;
      outsideMode <= 1'b0;
    end else begin
      if (strb.loadLo)   limLo       <= limData;
      if (strb.loadHi)   limHi       <= limData;
      if (strb.loadMode) outsideMode <= cfgOutside;
    end
  end

  // inclusive bounds; an inverted window leaves inWin false for every code
  always_comb begin
    geLo  = (convResult >= limLo);
    leHi  = (convResult <= limHi);
    inWin = geLo && leHi;
    hit   = outsideMode ? !inWin : inWin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             matchReg <= 1'b0;
    else if (strb.capture) matchReg <= hit;
  end

  assign matchFlag = matchReg;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(matchReg));

  assert_inverted_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && (limLo > limHi) && !outsideMode) |=> !matchReg);

  assert_inverted_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && (limLo > limHi) && outsideMode) |=> matchReg);

  assert_bounds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !outsideMode && (convResult == limLo) && (limLo <= limHi)) |=> matchReg);
endmodule

// File: rtl/adcwin_ctrl.sv
module adcwin_ctrl
  import adcwin_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      limLoWe,
  input  logic      limHiWe,
  input  logic      cfgWe,
  input  logic      cfgQualEn,
  input  logic      cfgIrqEn,
  input  logic      convDone,
  input  logic      irqClr,
  input  logic      hit,
  output dpStrobe_t strb,
  output logic      irqFlag
);
  logic qualEn, irqEn;
  logic setEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualEn <= 1'b0;
      irqEn  <= 1'b0;
    end else if (cfgWe) begin
      qualEn <= cfgQualEn;
      irqEn  <= cfgIrqEn;
    end
  end

  always_comb begin
    strb.loadLo   = limLoWe;
    strb.loadHi   = limHiWe;
    strb.loadMode = cfgWe;
    strb.capture  = convDone;
    setEvt        = convDone && irqEn && (!qualEn || hit);
  end

  // a set event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       irqFlag <= 1'b0;
    else if (setEvt) irqFlag <= 1'b1;
    else if (irqClr) irqFlag <= 1'b0;
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !setEvt) |=> !irqFlag);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && convDone && irqEn && !qualEn) |=> irqFlag);

  assert_unqualified_R6: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && irqEn && !qualEn) |=> irqFlag);

  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn && !irqFlag) |=> !irqFlag);

  assert_qualified_R7: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && qualEn && !hit && !irqFlag) |=> !irqFlag);
endmodule

// File: rtl/adc_window_qual.sv
module adc_window_qual
  import adcwin_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         limLoWe,
  input  logic         limHiWe,
  input  logic [W-1:0] limData,
  input  logic         cfgWe,
  input  logic         cfgOutside,
  input  logic         cfgQualEn,
  input  logic         cfgIrqEn,
  input  logic         convDone,
  input  logic [W-1:0] convResult,
  input  logic         irqClr,
  output logic         matchFlag,
  output logic         irqReq
);
  dpStrobe_t strb;
  logic      hit;

  adcwin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .limLoWe(limLoWe), .limHiWe(limHiWe),
    .cfgWe(cfgWe), .cfgQualEn(cfgQualEn), .cfgIrqEn(cfgIrqEn),
    .convDone(convDone), .irqClr(irqClr), .hit(hit),
    .strb(strb), .irqFlag(irqReq)
  );

  adcwin_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .limData(limData),
    .cfgOutside(cfgOutside), .convResult(convResult),
    .hit(hit), .matchFlag(matchFlag)
  );
endmodule

// File: tb/adc_window_qual_tb.sv
module adc_window_qual_tb;
  localparam int W = 10;

  logic clk = 0, rstN = 0;
  logic limLoWe = 0, limHiWe = 0, cfgWe = 0;
  logic [W-1:0] limData = '0, convResult = '0;
  logic cfgOutside = 0, cfgQualEn = 0, cfgIrqEn = 0;
  logic convDone = 0, irqClr = 0;
  logic matchFlag, irqReq;

  always #5 clk = ~clk;

  adc_window_qual #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .limLoWe(limLoWe), .limHiWe(limHiWe),
    .limData(limData), .cfgWe(cfgWe), .cfgOutside(cfgOutside),
    .cfgQualEn(cfgQualEn), .cfgIrqEn(cfgIrqEn), .convDone(convDone),
    .convResult(convResult), .irqClr(irqClr),
    .matchFlag(matchFlag), .irqReq(irqReq)
  );

  typedef struct {
    logic  m;
    logic  i;
    string tag;
  } item_t;

  item_t sbq[$];
  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  int  mLo = 0, mHi = 1023;
  bit  mOut = 0, mQual = 0, mIrqEn = 0, mIrq = 0;

  task automatic check(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic setLimits(int lo, int hi);
    @(negedge clk);
    limLoWe = 1; limHiWe = 0; limData = W'(lo);
    @(negedge clk);
    limLoWe = 0; limHiWe = 1; limData = W'(hi);
    @(negedge clk);
    limHiWe = 0;
    mLo = lo; mHi = hi;
  endtask

  task automatic setCfg(bit outside, bit qual, bit ien);
    @(negedge clk);
    cfgWe = 1; cfgOutside = outside; cfgQualEn = qual; cfgIrqEn = ien;
    @(negedge clk);
    cfgWe = 0;
    mOut = outside; mQual = qual; mIrqEn = ien;
  endtask

  // driver: predicts and pushes, then pulses convDone
  task automatic conv(int r, bit clr, string tag);
    item_t it;
    bit inW, h, ev;
    inW = (mLo <= r) && (r <= mHi);
    h   = mOut ? !inW : inW;
    ev  = mIrqEn && (!mQual || h);
    if (ev) mIrq = 1; else if (clr) mIrq = 0;
    it.m = h; it.i = mIrq; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    convDone = 1; convResult = W'(r); irqClr = clr;
    @(negedge clk);
    convDone = 0; irqClr = 0;
  endtask

  task automatic clearIrq();
    @(negedge clk);
    irqClr = 1;
    @(negedge clk);
    irqClr = 0;
    mIrq = 0;
    check("R9", irqReq, 1'b0, "irqReq after clear");
  endtask

  // monitor: pops one item for each accepted pulse
  initial begin
    forever begin
      @(posedge clk);
      if (convDone) begin
        @(negedge clk);
        if (sbq.size() == 0) begin
          total++; bad++;
          $display("FAIL scoreboard unexpected result actual=1 expected=0");
        end else begin
          item_t it;
          it = sbq.pop_front();
          check(it.tag, matchFlag, it.m, "matchFlag");
          check(it.tag, irqReq, it.i, "irqReq");
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", matchFlag, 1'b0, "matchFlag in reset");
    check("R1", irqReq, 1'b0, "irqReq in reset");
    rstN = 1;
    @(negedge clk);
    check("R1", matchFlag, 1'b0, "matchFlag after reset");
    check("R1", irqReq, 1'b0, "irqReq after reset");

    // R1 default full window, R8 interrupt disabled
    conv(0, 0, "R1");
    conv(1023, 0, "R8");

    // R6 unqualified: every result interrupts
    setLimits(100, 200);
    setCfg(0, 0, 1);
    conv(50, 0, "R6");
    clearIrq();
    conv(900, 0, "R6");
    clearIrq();

    // R7 and R2 qualified inside, bounds inclusive
    setCfg(0, 1, 1);
    conv(99, 0, "R7");
    conv(100, 0, "R2");
    clearIrq();
    conv(200, 0, "R2");
    clearIrq();
    conv(201, 0, "R7");
    // R9 sticky across a non-matching result
    conv(150, 0, "R9");
    conv(300, 0, "R9");
    repeat (3) @(negedge clk);
    check("R9", irqReq, 1'b1, "irqReq held idle");
    clearIrq();

    // R3 outside mode
    setCfg(1, 1, 1);
    conv(99, 0, "R3");
    clearIrq();
    conv(150, 0, "R3");
    conv(201, 0, "R3");
    // R10 set wins over simultaneous clear; clear wins with no event
    conv(0, 1, "R10");
    conv(100, 1, "R10");

    // R4 inverted window
    setLimits(300, 100);
    setCfg(0, 1, 1);
    conv(200, 0, "R4");
    conv(300, 0, "R4");
    conv(50, 0, "R4");
    setCfg(1, 1, 1);
    conv(200, 0, "R4");
    clearIrq();

    // R11 threshold use, limits take effect next cycle
    setLimits(512, 1023);
    setCfg(0, 1, 1);
    conv(511, 0, "R11");
    conv(512, 0, "R11");
    conv(1023, 0, "R11");
    clearIrq();
    setLimits(0, 10);
    conv(10, 0, "R11");
    conv(11, 0, "R11");

    // R5 flag holds while configuration changes
    setCfg(0, 0, 0);
    conv(5, 0, "R5");
    setLimits(600, 700);
    setCfg(1, 1, 0);
    repeat (2) @(negedge clk);
    check("R5", matchFlag, 1'b1, "matchFlag held");
    conv(650, 0, "R5");
    setLimits(0, 1023);
    repeat (2) @(negedge clk);
    check("R5", matchFlag, 1'b0, "matchFlag held");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule